// File: doc/BRIEF.md
# HD Line Number Checker

This block watches the luma word stream of a high-definition video link and checks the line number that follows each end-of-active-video timing marker. A separate timing generator, which runs locally and does not depend on the received data, supplies the line number the block expects. After each marker the block takes the next two strobed words as the line-number pair. It checks that each word is well formed, joins the two 11-bit fragments and compares the result with the expected count.

A mismatch raises a sticky error flag. A malformed or interrupted line-number pair also raises it, because the block treats such a pair as not received. The flag stays high until a one-cycle clear pulse arrives. When the link runs in standard-definition mode the block raises no error and drops any capture in progress. The chroma channel and the generation of the expected count are handled outside this block.

Top module: `hd_lnum_check`

## Requirements
- R1: After reset, `lnum_err` is low.
- R2: A word strobed (`word_vld`=1) together with `eav_seen`=1 marks the end of the timing marker. The next strobed word is the low line word, which carries line bits 6..0 in word bits 8..2. The strobed word after that is the high line word, which carries line bits 10..7 in word bits 5..2.
- R3: If the decoded line differs from `exp_line`, `lnum_err` goes high in the cycle after the high line word is strobed. `exp_line` is sampled in the same cycle as that word.
- R4: If the decoded line equals `exp_line`, `lnum_err` does not change.
- R5: A line word whose bit 9 is not the inverse of its bit 8 counts as missing. `lnum_err` goes high in the cycle after that word, and the capture is abandoned, so the word that follows is not taken as a line word.
- R6: A strobed word with `eav_seen`=1 that arrives before the high line word counts as a missing line number and sets `lnum_err`. It also starts a fresh capture, so the next two strobed words are taken as a new line-number pair.
- R7: While `hd_mode`=0, no error is raised and any capture in progress is dropped.
- R8: `lnum_err` stays high until `err_clr` is pulsed, and it is low in the cycle after that pulse.
- R9: When an error event and `err_clr` fall in the same cycle, the error wins and `lnum_err` stays high.
- R10: Cycles with `word_vld`=0 are ignored. This holds even when `eav_seen` is high in such a cycle, so gaps may separate the marker and the line words.
- R11: Strobed words that do not follow a marker never raise an error, whatever their content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| y_word | input | 10 | Luma data word |
| word_vld | input | 1 | Word strobe; `y_word` is valid in this cycle |
| eav_seen | input | 1 | The current strobed word closes an end-of-active-video marker |
| exp_line | input | 11 | Expected line number from local timing |
| hd_mode | input | 1 | 1 = high-definition mode, checking enabled |
| err_clr | input | 1 | One-cycle clear of the sticky error |
| lnum_err | output | 1 | Sticky line-number error flag |

## Verification
The bench drives line values that exercise each fragment boundary: bit 6 at the top of the low word and bit 7 at the bottom of the high word. A design that placed either fragment one bit off would report errors on matching lines or miss them on mismatching ones. It sends malformed words in both positions and then follows them with valid words that do not follow a marker. A design that kept capturing after a malformed word, or that checked stray words, would raise a spurious error. It also re-opens a marker midway through a pair, and checks that the pair after the new marker is the one compared. Further cases drop high-definition mode midway through a capture, place `eav_seen` and data on cycles without a strobe, and land a clear on the same edge as a new error.

// File: rtl/hd_lnum_pkg.sv
package hd_lnum_pkg;
  // capture sequencer states
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LO   = 2'd1,
    SEQ_HI   = 2'd2
  } seq_t;
endpackage

// File: rtl/lnum_seq.sv
module lnum_seq
  import hd_lnum_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic word_vld,
  input  logic eav_seen,
  input  logic hd_mode,
  input  logic word_ok,
  output logic take_lo,
  output logic take_hi,
  output logic miss
);
  seq_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    take_lo = 1'b0;
    take_hi = 1'b0;
    miss    = 1'b0;
    if (!hd_mode) begin
      state_d = SEQ_IDLE;
    end else if (word_vld) begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (eav_seen) state_d = SEQ_LO;
        end
        SEQ_LO: begin
          if (eav_seen) begin
            miss    = 1'b1;
            state_d = SEQ_LO;
          end else if (!word_ok) begin
            miss    = 1'b1;
            state_d = SEQ_IDLE;
          end else begin
            take_lo = 1'b1;
            state_d = SEQ_HI;
          end
        end
        SEQ_HI: begin
          if (eav_seen) begin
            miss    = 1'b1;
            state_d = SEQ_LO;
          end else if (!word_ok) begin
            miss    = 1'b1;
            state_d = SEQ_IDLE;
          end else begin
            take_hi = 1'b1;
            state_d = SEQ_IDLE;
          end
        end
        default: state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/lnum_capture.sv
module lnum_capture #(
  parameter int WORD_W  = 10,
  parameter int LINE_W  = 11,
  parameter int LO_BITS = 7,
  parameter int LO_LSB  = 2,
  parameter int HI_LSB  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] y_word,
  input  logic              take_lo,
  output logic              word_ok,
  output logic [LINE_W-1:0] rx_line
);
  localparam int HI_BITS = LINE_W - LO_BITS;

  logic [LO_BITS-1:0] lo_q, lo_d;

  // a line word must carry the inverse of bit WORD_W-2 in its top bit
  assign word_ok = (y_word[WORD_W-1] == ~y_word[WORD_W-2]);

  always_comb begin
    lo_d = lo_q;
    if (take_lo) lo_d = y_word[LO_LSB +: LO_BITS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_q <= '0;
    else        lo_q <= lo_d;
  end

  assign rx_line = {y_word[HI_LSB +: HI_BITS], lo_q};
endmodule

// File: rtl/lnum_cmp.sv
module lnum_cmp #(
  parameter int LINE_W = 11
) (
  input  logic              take_hi,
  input  logic              miss,
  input  logic [LINE_W-1:0] rx_line,
  input  logic [LINE_W-1:0] exp_line,
  output logic              err_set
);
  logic differ;
  assign differ  = |(rx_line ^ exp_line);
  assign err_set = miss | (take_hi & differ);
endmodule

// File: rtl/lnum_flag.sv
module lnum_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic err_set,
  input  logic err_clr,
  output logic flag
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (err_set)      flag_d = 1'b1;
    else if (err_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/hd_lnum_check.sv
module hd_lnum_check #(
  parameter int WORD_W  = 10,
  parameter int LINE_W  = 11,
  parameter int LO_BITS = 7,
  parameter int LO_LSB  = 2,
  parameter int HI_LSB  = 2,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] y_word,
  input  logic              word_vld,
  input  logic              eav_seen,
  input  logic [LINE_W-1:0] exp_line,
  input  logic              hd_mode,
  input  logic              err_clr,
  output logic              lnum_err
);
  // reset: asserts at once, releases after SYNC_N clock edges
  logic [SYNC_N-1:0] rst_pipe_q;
  logic              rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[SYNC_N-1];

  logic              word_ok;
  logic              take_lo;
  logic              take_hi;
  logic              miss;
  logic              err_set;
  logic [LINE_W-1:0] rx_line;

  lnum_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .word_vld (word_vld),
    .eav_seen (eav_seen),
    .hd_mode  (hd_mode),
    .word_ok  (word_ok),
    .take_lo  (take_lo),
    .take_hi  (take_hi),
    .miss     (miss)
  );

  lnum_capture #(
    .WORD_W  (WORD_W),
    .LINE_W  (LINE_W),
    .LO_BITS (LO_BITS),
    .LO_LSB  (LO_LSB),
    .HI_LSB  (HI_LSB)
  ) u_cap (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .y_word  (y_word),
    .take_lo (take_lo),
    .word_ok (word_ok),
    .rx_line (rx_line)
  );

  lnum_cmp #(.LINE_W(LINE_W)) u_cmp (
    .take_hi  (take_hi),
    .miss     (miss),
    .rx_line  (rx_line),
    .exp_line (exp_line),
    .err_set  (err_set)
  );

  lnum_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .err_set (err_set),
    .err_clr (err_clr),
    .flag    (lnum_err)
  );
endmodule

// File: rtl/hd_lnum_check_sva.sv
module hd_lnum_check_sva (
  input logic clk,
  input logic rst_n,
  input logic word_vld,
  input logic hd_mode,
  input logic err_clr,
  input logic err_set,
  input logic lnum_err
);
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lnum_err && !err_clr) |=> lnum_err); // R8

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !err_set) |=> !lnum_err); // R8

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> lnum_err); // R9

  AST_SD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !hd_mode |-> !err_set); // R7

  AST_SET_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |-> word_vld); // R10

  AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lnum_err) |-> $past(err_set)); // R3
endmodule

bind hd_lnum_check hd_lnum_check_sva i_sva (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .word_vld (word_vld),
  .hd_mode  (hd_mode),
  .err_clr  (err_clr),
  .err_set  (err_set),
  .lnum_err (lnum_err)
);

// File: tb/test_hd_lnum_check.sv
module test_hd_lnum_check;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  y_word;
  logic        word_vld;
  logic        eav_seen;
  logic [10:0] exp_line;
  logic        hd_mode;
  logic        err_clr;
  logic        lnum_err;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  hd_lnum_check i_hd_lnum_check (
    .clk(clk), .rst_n(rst_n), .y_word(y_word), .word_vld(word_vld),
    .eav_seen(eav_seen), .exp_line(exp_line), .hd_mode(hd_mode),
    .err_clr(err_clr), .lnum_err(lnum_err)
  );

  // {received line, expected line, expected error}
  localparam logic [22:0] VEC [10] = '{
    {11'd0,    11'd0,    1'b0},
    {11'd1,    11'd1,    1'b0},
    {11'd1125, 11'd1125, 1'b0},
    {11'd2047, 11'd2047, 1'b0},
    {11'd127,  11'd127,  1'b0},
    {11'd564,  11'd565,  1'b1},
    {11'd128,  11'd0,    1'b1},
    {11'd64,   11'd0,    1'b1},
    {11'd1024, 11'd0,    1'b1},
    {11'd5,    11'd1029, 1'b1}
  };

  function automatic logic [9:0] mk_lo(input logic [10:0] ln);
    logic [9:0] w;
    w      = '0;
    w[8:2] = ln[6:0];
    w[9]   = ~w[8];
    return w;
  endfunction

  function automatic logic [9:0] mk_hi(input logic [10:0] ln);
    logic [9:0] w;
    w      = '0;
    w[5:2] = ln[10:7];
    w[9]   = ~w[8];
    return w;
  endfunction

  task automatic chk(input string tag, input logic got, input logic want);
    n_run++;
    if (got !== want) begin
      n_fail++;
      $display("FAIL %s: lnum_err=%0b expected %0b", tag, got, want);
    end
  endtask

  task automatic put(input logic [9:0] w, input logic eav, input logic clr);
    @(negedge clk);
    y_word = w; word_vld = 1'b1; eav_seen = eav; err_clr = clr;
  endtask

  task automatic gap(input logic [9:0] w, input logic eav, input logic clr);
    @(negedge clk);
    y_word = w; word_vld = 1'b0; eav_seen = eav; err_clr = clr;
  endtask

  task automatic clear_flag();
    gap(10'h000, 1'b0, 1'b1);
    gap(10'h000, 1'b0, 1'b0);
  endtask

  // marker word then a well-formed line pair, then one idle cycle
  task automatic send_line(input logic [10:0] ln);
    put(10'h274, 1'b1, 1'b0);
    put(mk_lo(ln), 1'b0, 1'b0);
    put(mk_hi(ln), 1'b0, 1'b0);
    gap(10'h000, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: lnum_err=%0b expected run to end", lnum_err);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; y_word = '0; word_vld = 1'b0; eav_seen = 1'b0;
    exp_line = '0; hd_mode = 1'b1; err_clr = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset", lnum_err, 1'b0);

    // R2 R3 R4: vector table
    for (int i = 0; i < 10; i++) begin
      clear_flag();
      exp_line = VEC[i][11:1];
      send_line(VEC[i][22:12]);
      chk($sformatf("R2/R3/R4 vec %0d", i), lnum_err, VEC[i][0]);
    end

    // R5: malformed low word, then stray words must not be captured (R11)
    clear_flag();
    exp_line = 11'd99;
    put(10'h274, 1'b1, 1'b0);
    put(10'h300, 1'b0, 1'b0);
    gap(10'h000, 1'b0, 1'b0);
    chk("R5 bad low word", lnum_err, 1'b1);
    clear_flag();
    put(mk_lo(11'd3), 1'b0, 1'b0);
    put(mk_hi(11'd3), 1'b0, 1'b0);
    gap(10'h000, 1'b0, 1'b0);
    chk("R5 capture abandoned", lnum_err, 1'b0);

    // R5: malformed high word
    clear_flag();
    exp_line = 11'd300;
    put(10'h274, 1'b1, 1'b0);
    put(mk_lo(11'd300), 1'b0, 1'b0);
    put(10'h000, 1'b0, 1'b0);
    gap(10'h000, 1'b0, 1'b0);
    chk("R5 bad high word", lnum_err, 1'b1);

    // R11: arbitrary words with no marker
    clear_flag();
    put(10'h300, 1'b0, 1'b0);
    put(10'h000, 1'b0, 1'b0);
    put(mk_lo(11'd7), 1'b0, 1'b0);
    put(mk_hi(11'd7), 1'b0, 1'b0);
    gap(10'h000, 1'b0, 1'b0);
    chk("R11 stray words", lnum_err, 1'b0);

    // R6: marker re-opens before the pair completes
    clear_flag();
    exp_line = 11'd8;
    put(10'h274, 1'b1, 1'b0);
    put(mk_lo(11'd8), 1'b0, 1'b0);
    put(10'h274, 1'b1, 1'b0);
    gap(10'h000, 1'b0, 1'b0);
    chk("R6 interrupted pair", lnum_err, 1'b1);
    gap(10'h000, 1'b0, 1'b1);
    gap(10'h000, 1'b0, 1'b0);
    chk("R8 clear after interrupt", lnum_err, 1'b0);
    put(mk_lo(11'd7), 1'b0, 1'b0);
    put(mk_hi(11'd7), 1'b0, 1'b0);
    gap(10'h000, 1'b0, 1'b0);
    chk("R6 restart captures new pair", lnum_err, 1'b1);

    // R7: standard-definition mode stays quiet
    clear_flag();
    hd_mode = 1'b0;
    exp_line = 11'd1;
    send_line(11'd500);
    chk("R7 sd mode mismatch", lnum_err, 1'b0);
    hd_mode = 1'b1;
    put(10'h274, 1'b1, 1'b0);
    hd_mode = 1'b0;
    put(mk_lo(11'd500), 1'b0, 1'b0);
    hd_mode = 1'b1;
    put(mk_hi(11'd500), 1'b0, 1'b0);
    gap(10'h000, 1'b0, 1'b0);
    chk("R7 capture dropped", lnum_err, 1'b0);

    // R10: gaps with data and marker on unstrobed cycles
    clear_flag();
    exp_line = 11'd777;
    put(10'h274, 1'b1, 1'b0);
    gap(10'h300, 1'b1, 1'b0);
    gap(mk_lo(11'd1), 1'b0, 1'b0);
    put(mk_lo(11'd777), 1'b0, 1'b0);
    gap(10'h000, 1'b1, 1'b0);
    put(mk_hi(11'd777), 1'b0, 1'b0);
    gap(10'h000, 1'b0, 1'b0);
    chk("R10 gaps ignored match", lnum_err, 1'b0);
    put(10'h274, 1'b1, 1'b0);
    gap(10'h000, 1'b0, 1'b0);
    put(mk_lo(11'd776), 1'b0, 1'b0);
    gap(10'h3FF, 1'b0, 1'b0);
    put(mk_hi(11'd776), 1'b0, 1'b0);
    gap(10'h000, 1'b0, 1'b0);
    chk("R10 gaps ignored mismatch", lnum_err, 1'b1);

    // R8: sticky hold then clear
    repeat (5) gap(10'h000, 1'b0, 1'b0);
    chk("R8 sticky hold", lnum_err, 1'b1);
    gap(10'h000, 1'b0, 1'b1);
    gap(10'h000, 1'b0, 1'b0);
    chk("R8 clear pulse", lnum_err, 1'b0);

    // R9: clear on the same edge as a new error
    exp_line = 11'd10;
    put(10'h274, 1'b1, 1'b0);
    put(mk_lo(11'd11), 1'b0, 1'b0);
    put(mk_hi(11'd11), 1'b0, 1'b1);
    gap(10'h000, 1'b0, 1'b0);
    chk("R9 set beats clear", lnum_err, 1'b1);

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule